// File: doc/BRIEF.md
# Sub-array Sleep and Wake Controller

This block handles power for a memory block made of four sub-arrays. It sits between the request port and the arrays and decides which sub-arrays have their clock running and which have their sleep devices engaged. The top address bits of each request pick the target sub-array. The remaining bits, the write flag and the write data go one cycle later to the array side, together with a one-hot select.

Waking happens in two steps. Any request that arrives while sub-arrays are sleeping moves every enabled, sleeping sub-array into a partial-wake state. In that state the sleep devices are partly on and the local timers and decoders run. The addressed sub-array is accepted in that state and becomes fully active in the next cycle, so a cold access costs one stall cycle. Each sub-array has its own 8-bit countdown. An access reloads the countdown from a programmable delay, and the sub-array goes back to sleep with its clock gated when the countdown runs out.

A per-sub-array disable setting parks a faulty sub-array, or one whose contents may be lost, in its lowest-leakage state. The delays and disable bits arrive over a serial scan chain and take effect when an update strobe copies the chain into the live settings.

Top module: `subarray_sleep_ctrl`

## Requirements
- R1: `reqAddr[13:12]` selects the sub-array. One cycle after a request is accepted, `arrayValid` is high, `arraySel` has exactly the bit of that index set, `arrayRow` equals `reqAddr[11:0]`, and `arrayWe` and `arrayWdata` carry the request's write flag and data. With no access, `arrayValid` and `arraySel` are zero.
- R2: A request whose target is sleeping and enabled sees `reqReady` low. In the next cycle every enabled sub-array that was sleeping shows `earlyWake` high, `sleepEn` low and `clkEn` low.
- R3: `reqReady` is high when the target is in partial wake, active, or disabled. An accepted request to a sub-array in partial wake makes it fully active (`clkEn` high) in the next cycle. `clkEn` never rises unless `earlyWake` was high in the cycle before.
- R4: A sub-array in partial wake that is not addressed stays in partial wake while any request is present, and returns to sleep in the cycle after a cycle with no request.
- R5: If the last accepted request to a sub-array with delay D is in cycle a, that sub-array has `clkEn` high from a+1 through a+1+D and is asleep (`sleepEn` high, `clkEn` low) from a+2+D. An access to an active sub-array reloads the countdown and adds no stall.
- R6: With D = 0 the sub-array is active only in the single cycle in which the array access is presented, and it sleeps in the cycle after.
- R7: Whatever requests arrive, a disabled sub-array shows `retainOff` high, `sleepEn` high, `clkEn` low and `earlyWake` low. A request to it is accepted at once and produces no array access. When the disable bit is cleared, it returns to plain sleep.
- R8: When `cfgShiftEn` is high, a 36-bit chain shifts left by one bit each cycle and takes `cfgShiftIn` into bit 0. The delay of sub-array i sits in chain bits [8i+7:8i] and its disable bit in chain bit 32+i. A `cfgUpdate` cycle copies the chain (its value before that cycle's shift) into the live settings, which govern state changes from the following clock edge on.
- R9: A synchronous reset puts all sub-arrays to sleep: `sleepEn` all ones, and `clkEn`, `earlyWake`, `retainOff` and `arrayValid` all zero. All disable bits clear and every delay is set to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 14 | Request address; bits 13:12 select the sub-array |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | Request accepted this cycle when high together with reqValid |
| cfgShiftEn | input | 1 | Shift the configuration chain |
| cfgShiftIn | input | 1 | Serial configuration bit |
| cfgUpdate | input | 1 | Copy the chain into the live settings |
| earlyWake | output | 4 | Per sub-array partial wake (partial wake or active) |
| clkEn | output | 4 | Per sub-array clock enable (fully active) |
| sleepEn | output | 4 | Per sub-array sleep-device enable |
| retainOff | output | 4 | Per sub-array no-retention, lowest-leakage state |
| arrayValid | output | 1 | Array access presented this cycle |
| arraySel | output | 4 | One-hot sub-array select of the access |
| arrayRow | output | 12 | Address within the sub-array |
| arrayWe | output | 1 | Access is a write |
| arrayWdata | output | 32 | Write data to the array |

## Verification
The hardest situations to reach from the ports are the boundaries between states. One is an access that lands exactly in the cycle in which a sub-array's countdown reaches zero. Another is a configuration update that disables a sub-array while a request to it is held. A third is a run of back-to-back requests that keeps non-addressed sub-arrays in partial wake for many cycles. The stimulus reaches these by reloading the scan chain every few hundred cycles with small random delays (zero included) and random disable masks. Between reloads it switches among sparse, medium and dense request traffic, so that countdowns expire both during traffic and after it stops. Directed cases measure the active window for a mid-range delay, for a zero delay and for the reset delay, and cover a request to a disabled sub-array.

// File: rtl/sspc_pkg.sv
package sspc_pkg;

  typedef enum logic [1:0] {
    SA_SLEEP  = 2'd0,
    SA_EARLY  = 2'd1,
    SA_ACTIVE = 2'd2,
    SA_OFF    = 2'd3
  } saState_t;

  // strobes from control into the access/config datapath
  typedef struct packed {
    logic issue;    // accepted request goes to the array next cycle
    logic writeOp;  // that request is a write
  } accStrobe_t;

endpackage

// File: rtl/sspc_unit.sv
module sspc_unit
  import sspc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             offCfg,
  input  logic [CNT_W-1:0] delayCfg,
  input  logic             anyReq,
  input  logic             hit,
  output saState_t         state
);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SA_SLEEP;
      idleCnt <= '0;
    end else if (offCfg) begin
      state   <= SA_OFF;
      idleCnt <= '0;
    end else begin
      case (state)
        SA_OFF:   state <= SA_SLEEP;
        SA_SLEEP: if (anyReq) state <= SA_EARLY;
        SA_EARLY: begin
          if (hit) begin
            state   <= SA_ACTIVE;
            idleCnt <= delayCfg;
          end else if (!anyReq) begin
            state <= SA_SLEEP;
          end
        end
        SA_ACTIVE: begin
          if (hit)                idleCnt <= delayCfg;
          else if (idleCnt == '0) state   <= SA_SLEEP;
          else                    idleCnt <= idleCnt - 1'b1;
        end
        default: state <= SA_SLEEP;
      endcase
    end
  end

endmodule

// File: rtl/sspc_ctrl.sv
module sspc_ctrl
  import sspc_pkg::*;
#(
  parameter int SUB_N = 4,
  parameter int CNT_W = 8,
  localparam int SEL_W = $clog2(SUB_N)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [SEL_W-1:0]            tgtIdx,
  input  logic [SUB_N-1:0]            cfgOff,
  input  logic [SUB_N-1:0][CNT_W-1:0] cfgDelay,
  output logic                        reqReady,
  output accStrobe_t                  strobe,
  output logic [SUB_N-1:0]            earlyWake,
  output logic [SUB_N-1:0]            clkEn,
  output logic [SUB_N-1:0]            sleepEn,
  output logic [SUB_N-1:0]            retainOff
);

  saState_t unitState [SUB_N];
  saState_t tgtState;
  logic     tgtOff;

  for (genvar gi = 0; gi < SUB_N; gi++) begin : g_unit
    logic unitHit;
    assign unitHit = reqValid && (tgtIdx == SEL_W'(gi));

    sspc_unit #(.CNT_W(CNT_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .offCfg   (cfgOff[gi]),
      .delayCfg (cfgDelay[gi]),
      .anyReq   (reqValid),
      .hit      (unitHit),
      .state    (unitState[gi])
    );

    assign earlyWake[gi] = (unitState[gi] == SA_EARLY) || (unitState[gi] == SA_ACTIVE);
    assign clkEn[gi]     = (unitState[gi] == SA_ACTIVE);
    assign sleepEn[gi]   = (unitState[gi] == SA_SLEEP) || (unitState[gi] == SA_OFF);
    assign retainOff[gi] = (unitState[gi] == SA_OFF);
  end

  assign tgtState = unitState[tgtIdx];
  assign tgtOff   = cfgOff[tgtIdx];

  always_comb begin
    reqReady       = tgtOff || (tgtState != SA_SLEEP);
    strobe.issue   = reqValid && !tgtOff &&
                     ((tgtState == SA_EARLY) || (tgtState == SA_ACTIVE));
    strobe.writeOp = strobe.issue && reqWrite;
  end

endmodule

// File: rtl/sspc_path.sv
module sspc_path
  import sspc_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int SUB_N       = 4,
  parameter int CNT_W       = 8,
  parameter int RESET_DELAY = 4,
  localparam int SEL_W   = $clog2(SUB_N),
  localparam int ROW_W   = ADDR_W - SEL_W,
  localparam int DLY_W   = SUB_N * CNT_W,
  localparam int CHAIN_W = DLY_W + SUB_N
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfgShiftEn,
  input  logic                        cfgShiftIn,
  input  logic                        cfgUpdate,
  input  accStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic [SUB_N-1:0][CNT_W-1:0] cfgDelay,
  output logic [SUB_N-1:0]            cfgOff,
  output logic                        arrayValid,
  output logic [SUB_N-1:0]            arraySel,
  output logic [ROW_W-1:0]            arrayRow,
  output logic                        arrayWe,
  output logic [DATA_W-1:0]           arrayWdata
);

  logic [CHAIN_W-1:0] scanChain;
  logic [SEL_W-1:0]   selIdx;

  // serial chain plus live copy
  always_ff @(posedge clk) begin
    if (rst) begin
      scanChain <= '0;
      cfgDelay  <= {SUB_N{CNT_W'(RESET_DELAY)}};
      cfgOff    <= '0;
    end else begin
      if (cfgShiftEn) scanChain <= {scanChain[CHAIN_W-2:0], cfgShiftIn};
      if (cfgUpdate) begin
        cfgDelay <= scanChain[DLY_W-1:0];
        cfgOff   <= scanChain[CHAIN_W-1 -: SUB_N];
      end
    end
  end

  // one register stage toward the arrays
  always_ff @(posedge clk) begin
    if (rst) begin
      arrayValid <= 1'b0;
      selIdx     <= '0;
      arrayRow   <= '0;
      arrayWe    <= 1'b0;
      arrayWdata <= '0;
    end else begin
      arrayValid <= strobe.issue;
      if (strobe.issue) begin
        selIdx     <= reqAddr[ADDR_W-1 -: SEL_W];
        arrayRow   <= reqAddr[ROW_W-1:0];
        arrayWe    <= strobe.writeOp;
        arrayWdata <= reqWdata;
      end
    end
  end

  for (genvar gi = 0; gi < SUB_N; gi++) begin : g_sel
    assign arraySel[gi] = arrayValid && (selIdx == SEL_W'(gi));
  end

endmodule

// File: rtl/subarray_sleep_ctrl.sv
module subarray_sleep_ctrl
  import sspc_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int SUB_N       = 4,
  parameter int CNT_W       = 8,
  parameter int RESET_DELAY = 4,
  localparam int SEL_W = $clog2(SUB_N),
  localparam int ROW_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              cfgShiftEn,
  input  logic              cfgShiftIn,
  input  logic              cfgUpdate,
  output logic [SUB_N-1:0]  earlyWake,
  output logic [SUB_N-1:0]  clkEn,
  output logic [SUB_N-1:0]  sleepEn,
  output logic [SUB_N-1:0]  retainOff,
  output logic              arrayValid,
  output logic [SUB_N-1:0]  arraySel,
  output logic [ROW_W-1:0]  arrayRow,
  output logic              arrayWe,
  output logic [DATA_W-1:0] arrayWdata
);

  accStrobe_t                  strobe;
  logic [SUB_N-1:0][CNT_W-1:0] cfgDelay;
  logic [SUB_N-1:0]            cfgOff;

  sspc_ctrl #(.SUB_N(SUB_N), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .tgtIdx    (reqAddr[ADDR_W-1 -: SEL_W]),
    .cfgOff    (cfgOff),
    .cfgDelay  (cfgDelay),
    .reqReady  (reqReady),
    .strobe    (strobe),
    .earlyWake (earlyWake),
    .clkEn     (clkEn),
    .sleepEn   (sleepEn),
    .retainOff (retainOff)
  );

  sspc_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_N(SUB_N),
    .CNT_W(CNT_W), .RESET_DELAY(RESET_DELAY)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .cfgShiftEn (cfgShiftEn),
    .cfgShiftIn (cfgShiftIn),
    .cfgUpdate  (cfgUpdate),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .cfgDelay   (cfgDelay),
    .cfgOff     (cfgOff),
    .arrayValid (arrayValid),
    .arraySel   (arraySel),
    .arrayRow   (arrayRow),
    .arrayWe    (arrayWe),
    .arrayWdata (arrayWdata)
  );

endmodule

// File: rtl/sspc_checker.sv
module sspc_checker #(
  parameter int SUB_N = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic [SEL_W-1:0] reqTgt,
  input logic             reqReady,
  input logic [SUB_N-1:0] earlyWake,
  input logic [SUB_N-1:0] clkEn,
  input logic [SUB_N-1:0] sleepEn,
  input logic [SUB_N-1:0] retainOff,
  input logic             arrayValid,
  input logic [SUB_N-1:0] arraySel
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arraySel)); // R1

  AST_ACCESS_CLOCKED: assert property (@(posedge clk) disable iff (rst)
    arrayValid |-> ((arraySel & ~clkEn) == '0)); // R3

  AST_NO_DISABLED_ACCESS: assert property (@(posedge clk) disable iff (rst)
    arrayValid |-> ((arraySel & retainOff) == '0)); // R7

  AST_STALL_WAKES: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=> earlyWake[$past(reqTgt)]); // R2

  AST_RESET_SLEEP: assert property (@(posedge clk)
    rst |=> ((sleepEn == '1) && (clkEn == '0) && !arrayValid)); // R9

  for (genvar gi = 0; gi < SUB_N; gi++) begin : g_unit
    AST_WAKE_VIA_EARLY: assert property (@(posedge clk) disable iff (rst)
      $rose(clkEn[gi]) |-> $past(earlyWake[gi])); // R3
  end

endmodule

bind subarray_sleep_ctrl sspc_checker #(.SUB_N(SUB_N), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reqValid   (reqValid),
  .reqTgt     (reqAddr[ADDR_W-1 -: SEL_W]),
  .reqReady   (reqReady),
  .earlyWake  (earlyWake),
  .clkEn      (clkEn),
  .sleepEn    (sleepEn),
  .retainOff  (retainOff),
  .arrayValid (arrayValid),
  .arraySel   (arraySel)
);

// File: tb/subarray_sleep_ctrl_test.sv
module subarray_sleep_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [13:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic        cfgShiftEn = 1'b0, cfgShiftIn = 1'b0, cfgUpdate = 1'b0;
  logic [3:0]  earlyWake, clkEn, sleepEn, retainOff, arraySel;
  logic        arrayValid, arrayWe;
  logic [11:0] arrayRow;
  logic [31:0] arrayWdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  subarray_sleep_ctrl uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .cfgShiftEn(cfgShiftEn), .cfgShiftIn(cfgShiftIn), .cfgUpdate(cfgUpdate),
    .earlyWake(earlyWake), .clkEn(clkEn), .sleepEn(sleepEn), .retainOff(retainOff),
    .arrayValid(arrayValid), .arraySel(arraySel), .arrayRow(arrayRow),
    .arrayWe(arrayWe), .arrayWdata(arrayWdata)
  );

  int total = 0;
  int bad   = 0;

  // reference model: 0 sleep, 1 partial wake, 2 active, 3 disabled
  int          mSt [4];
  int          mCnt [4];
  int          mDelay [4];
  logic [3:0]  mOff;
  logic [35:0] mChain;
  logic        mValid;
  int          mSel;
  logic [11:0] mRow;
  logic        mWe;
  logic [31:0] mWd;
  logic        lastReady;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < 4; i++) begin
      mSt[i] = 0; mCnt[i] = 0; mDelay[i] = 4;
    end
    mOff = '0; mChain = '0; mValid = 1'b0; mSel = 0;
    mRow = '0; mWe = 1'b0; mWd = '0;
  endfunction

  function automatic logic [3:0] stVec(input int code);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (mSt[i] == code);
    return r;
  endfunction

  task automatic tick(input logic v, input logic w, input logic [13:0] a,
                      input logic [31:0] d, input logic se, input logic si,
                      input logic up);
    int   tgt;
    logic expRdy, iss, hit;
    int   nst, ncnt;
    reqValid = v; reqWrite = w; reqAddr = a; reqWdata = d;
    cfgShiftEn = se; cfgShiftIn = si; cfgUpdate = up;
    #1;
    tgt = int'(a[13:12]);
    lastReady = reqReady;
    if (!rst) begin
      expRdy = mOff[tgt] || (mSt[tgt] != 0);
      check("R3 reqReady", reqReady, expRdy);
      check("R2 earlyWake", earlyWake, stVec(1) | stVec(2));
      check("R5 clkEn", clkEn, stVec(2));
      check("R5 sleepEn", sleepEn, stVec(0) | stVec(3));
      check("R7 retainOff", retainOff, stVec(3));
      check("R1 arrayValid", arrayValid, mValid);
      check("R1 arraySel", arraySel, mValid ? (4'b1 << mSel) : 4'b0);
      if (mValid) begin
        check("R1 arrayRow", arrayRow, mRow);
        check("R1 arrayWe", arrayWe, mWe);
        check("R1 arrayWdata", arrayWdata, mWd);
      end
    end
    // advance model to the next clock edge
    if (rst) begin
      modelReset();
    end else begin
      iss = v && !mOff[tgt] && (mSt[tgt] == 1 || mSt[tgt] == 2);
      for (int i = 0; i < 4; i++) begin
        hit = v && (tgt == i);
        nst = mSt[i]; ncnt = mCnt[i];
        if (mOff[i]) begin
          nst = 3; ncnt = 0;
        end else begin
          case (mSt[i])
            3: nst = 0;
            0: if (v) nst = 1;
            1: if (hit) begin nst = 2; ncnt = mDelay[i]; end
               else if (!v) nst = 0;
            default: if (hit) ncnt = mDelay[i];
                     else if (mCnt[i] == 0) nst = 0;
                     else ncnt = mCnt[i] - 1;
          endcase
        end
        mSt[i] = nst; mCnt[i] = ncnt;
      end
      mValid = iss;
      if (iss) begin
        mSel = tgt; mRow = a[11:0]; mWe = w; mWd = d;
      end
      if (up) begin
        for (int i = 0; i < 4; i++) mDelay[i] = int'(mChain[i*8 +: 8]);
        mOff = mChain[35:32];
      end
      if (se) mChain = {mChain[34:0], si};
    end
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b0, 1'b0, 14'h0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // R8: shift bit 35 first, then one update cycle
  task automatic loadCfg(input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3,
                         input logic [3:0] off);
    logic [35:0] cv;
    cv = {off, d3, d2, d1, d0};
    for (int k = 35; k >= 0; k--)
      tick(1'b0, 1'b0, 14'h0, 32'h0, 1'b1, cv[k], 1'b0);
    tick(1'b0, 1'b0, 14'h0, 32'h0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic issueReq(input logic w, input logic [13:0] a, input logic [31:0] d);
    for (int k = 0; k < 6; k++) begin
      tick(1'b1, w, a, d, 1'b0, 1'b0, 1'b0);
      if (lastReady) break;
    end
  endtask

  task automatic measureSpan(input int idx, output int span);
    span = 0;
    for (int k = 0; k < 40; k++) begin
      if (clkEn[idx]) span++;
      idle();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL R9 watchdog expired act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int span;
    int tgt;
    logic [3:0] offMask;
    void'($urandom(32'h1c3a5));
    modelReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check("R9 sleepEn", sleepEn, 4'hF);
    check("R9 clkEn", clkEn, 4'h0);
    check("R9 earlyWake", earlyWake, 4'h0);
    check("R9 retainOff", retainOff, 4'h0);
    check("R9 arrayValid", arrayValid, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset delay of 4 -> active for 5 cycles
    issueReq(1'b0, {2'd0, 12'h123}, 32'h0);
    measureSpan(0, span);
    check("R9 reset delay span", span, 5);

    // R8 R5: delays 3,0,7,1 via scan
    loadCfg(8'd3, 8'd0, 8'd7, 8'd1, 4'b0000);
    idle();
    issueReq(1'b1, {2'd2, 12'hABC}, 32'hDEADBEEF);
    measureSpan(2, span);
    check("R5 R8 span delay 7", span, 8);

    // R6 zero delay
    issueReq(1'b0, {2'd1, 12'h055}, 32'h0);
    measureSpan(1, span);
    check("R6 span delay 0", span, 1);

    // R4: partial wake of others held while requests continue
    issueReq(1'b1, {2'd0, 12'h001}, 32'h11);
    tick(1'b1, 1'b0, {2'd0, 12'h002}, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R4 others held in partial wake", earlyWake & ~clkEn, 4'b1110);
    idle();
    idle();
    check("R4 others back to sleep", sleepEn & 4'b1110, 4'b1110);
    repeat (10) idle();

    // R7 disable sub-array 3
    loadCfg(8'd2, 8'd2, 8'd2, 8'd2, 4'b1000);
    idle(); idle();
    check("R7 disabled state", retainOff, 4'b1000);
    tick(1'b1, 1'b1, {2'd3, 12'h777}, 32'h5, 1'b0, 1'b0, 1'b0);
    check("R7 request to disabled accepted", lastReady, 1'b1);
    check("R7 no array access", arrayValid, 1'b0);
    issueReq(1'b0, {2'd0, 12'h010}, 32'h0);
    check("R7 disabled ignores wake", {earlyWake[3], clkEn[3], sleepEn[3]}, 3'b001);
    repeat (6) idle();
    loadCfg(8'd2, 8'd2, 8'd2, 8'd2, 4'b0000);
    idle(); idle();
    check("R7 re-enabled sleeps", {retainOff[3], sleepEn[3]}, 2'b01);

    // random phases with config reloads
    for (int blk = 0; blk < 8; blk++) begin
      offMask = (($urandom % 3) == 0) ? (4'b1 << ($urandom % 4)) : 4'b0;
      loadCfg(8'($urandom % 12), 8'($urandom % 4), 8'($urandom % 12),
              8'($urandom % 6), offMask);
      for (int k = 0; k < 400; k++) begin
        logic v;
        case (blk % 3)
          0: v = (($urandom % 8) == 0);
          1: v = (($urandom % 3) == 0);
          default: v = (($urandom % 4) != 0);
        endcase
        tgt = int'($urandom % 4);
        tick(v, 1'($urandom), {2'(tgt), 12'($urandom)}, $urandom,
             1'b0, 1'b0, 1'b0);
      end
    end
    repeat (20) idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule